// File: doc/BRIEF.md
# Double-to-Single Store Narrowing Unit

This unit turns a 64-bit double-precision register image into the 32-bit single-precision word that a store-single operation writes to memory. The conversion never rounds. Fraction bits below the single fraction field are dropped. Values whose magnitude is at least the smallest normal single are narrowed by copying fixed bit fields, and this includes values too large for single format, infinities and NaNs. Values that land in the single denormal range are shifted into a denormal fraction. Anything smaller, if nonzero, becomes a zero with the input's sign.

The caller presents a word together with a valid strobe. One clock later the registered result appears together with an output valid. The result register loads only on cycles where the strobe is high, so the last result stays on the output while the input is idle.

Top module: `narrow_store_unit`

## Requirements
- R1: With e = in_word[62:52] − 1023, if e > −127 the result is {in[63], in[62], in[58:52], in[51:29]}, with the exponent in result bits 30..23 and the fraction in bits 22..0 (for example, 0x3FF0000000000000 gives 0x3F800000).
- R2: Input bits 28..0 never change the result, whatever their value. There is no rounding.
- R3: Infinities, NaNs and magnitudes above the largest single use the same field copy as R1, with no saturation (for example, 2^200 gives 0x63800000).
- R4: An input whose bits 62..0 are all zero gives {in[63], 31 zeros}.
- R5: If −149 ≤ e ≤ −127, then result bits 30..23 are zero. Result bits 22..0 are {1, in[51:29]} shifted right by (−126 − e), which is 1 to 23 places.
- R6: If e < −149 and bits 62..0 are not all zero, the result is {in[63], 31 zeros}.
- R7: Result bit 31 always equals input bit 63.
- R8: out_vld is high in the cycle after a cycle with in_vld high, and low in the cycle after a cycle with in_vld low. The result of an accepted input is on out_word in that following cycle.
- R9: While in_vld is low, out_word keeps its previous value, whatever in_word carries.
- R10: A synchronous active-high rst clears out_vld, even when in_vld is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_word | input | 64 | Double-precision register image |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_word | output | 32 | Registered single-precision store word |

## Verification
Every result is due exactly one rising edge after the edge that samples its input. The bench drives each input on a falling edge. It then waits for one rising edge and compares out_vld and out_word at the following falling edge, so each check reads the register that edge loaded. The hold and idle checks drive in_vld low with a different word and sample at the same point. There they confirm that out_word has kept the earlier result and that out_vld has dropped. The reset check holds in_vld high during reset and expects out_vld low after that edge.

// File: rtl/nsu_pkg.sv
package nsu_pkg;

  // Which conversion path a source value takes
  typedef enum logic [1:0] {
    PATH_COPY  = 2'd0,  // direct field copy (normal, zero, inf, NaN, overflow)
    PATH_SUBN  = 2'd1,  // shift into single denormal
    PATH_FLUSH = 2'd2   // below denormal range: signed zero
  } path_e;

endpackage

// File: rtl/nsu_classify.sv
module nsu_classify
  import nsu_pkg::*;
#(
  parameter int SE  = 11,
  parameter int SM  = 52,
  parameter int DE  = 8,
  parameter int DM  = 23,
  parameter int SHW = $clog2(DM + 1)
) (
  input  logic [SE+SM-1:0] mag,
  output path_e            path,
  output logic [SHW-1:0]   shamt
);

  localparam int BIAS_S   = (1 << (SE - 1)) - 1;
  localparam int BIAS_D   = (1 << (DE - 1)) - 1;
  localparam int COPY_MIN = BIAS_S - BIAS_D + 1;  // smallest raw exponent copied
  localparam int SUBN_MIN = COPY_MIN - DM;        // smallest raw exponent shifted

  logic [SE-1:0] raw_exp;
  logic          mag_zero;
  logic [SE-1:0] diff;

  assign raw_exp  = mag[SE+SM-1:SM];
  assign mag_zero = ~|mag;
  assign diff     = SE'(COPY_MIN) - raw_exp;

  always_comb begin
    if (mag_zero || (raw_exp >= SE'(COPY_MIN))) begin
      path = PATH_COPY;
    end else if (raw_exp >= SE'(SUBN_MIN)) begin
      path = PATH_SUBN;
    end else begin
      path = PATH_FLUSH;
    end
  end

  always_comb begin
    if (path == PATH_SUBN) shamt = diff[SHW-1:0];
    else                   shamt = '0;
  end

  // R5
  always_comb begin
    if (path == PATH_SUBN) begin
      subn_range_chk: assert ((diff != '0) && (diff <= SE'(DM)))
        else $error("denormal shift out of range");
    end
  end

endmodule

// File: rtl/nsu_subnorm_shift.sv
module nsu_subnorm_shift #(
  parameter int DM  = 23,
  parameter int SHW = $clog2(DM + 1)
) (
  input  logic [DM-1:0]  man_hi,
  input  logic [SHW-1:0] shamt,
  output logic [DM-1:0]  frac
);

  // stage 0 carries the hidden one above the kept fraction bits
  logic [DM:0] stg [0:SHW];

  assign stg[0] = {1'b1, man_hi};

  genvar g;
  generate
    for (g = 0; g < SHW; g++) begin : g_stage
      assign stg[g+1] = shamt[g] ? (stg[g] >> (1 << g)) : stg[g];
    end
  endgenerate

  assign frac = stg[SHW][DM-1:0];

  // R5
  always_comb begin
    if (shamt != '0) begin
      hidden_gone_chk: assert (stg[SHW][DM] == 1'b0)
        else $error("hidden bit left in exponent position");
    end
  end

endmodule

// File: rtl/nsu_pack.sv
module nsu_pack
  import nsu_pkg::*;
#(
  parameter int DE = 8,
  parameter int DM = 23,
  localparam int DW = 1 + DE + DM
) (
  input  logic          sign,
  input  logic          exp_top,
  input  logic [DE-2:0] exp_low,
  input  logic [DM-1:0] man_hi,
  input  logic [DM-1:0] subn_frac,
  input  path_e         path,
  output logic [DW-1:0] word
);

  always_comb begin
    unique case (path)
      PATH_COPY: word = {sign, exp_top, exp_low, man_hi};
      PATH_SUBN: word = {sign, {DE{1'b0}}, subn_frac};
      default:   word = {sign, {(DW-1){1'b0}}};
    endcase
  end

endmodule

// File: rtl/nsu_out_reg.sv
module nsu_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] d,
  output logic         out_vld,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) q <= d;
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(q));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_vld);

endmodule

// File: rtl/narrow_store_unit.sv
module narrow_store_unit
  import nsu_pkg::*;
#(
  parameter int SE = 11,
  parameter int SM = 52,
  parameter int DE = 8,
  parameter int DM = 23,
  localparam int SW   = 1 + SE + SM,
  localparam int DW   = 1 + DE + DM,
  localparam int SHW  = $clog2(DM + 1),
  localparam int DROP = SM - DM
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [SW-1:0] in_word,
  output logic          out_vld,
  output logic [DW-1:0] out_word
);

  path_e          path;
  logic [SHW-1:0] shamt;
  logic [DM-1:0]  man_hi;
  logic [DM-1:0]  subn_frac;
  logic [DW-1:0]  next_word;

  assign man_hi = in_word[SM-1:DROP];

  nsu_classify #(.SE(SE), .SM(SM), .DE(DE), .DM(DM), .SHW(SHW)) u_classify (
    .mag   (in_word[SW-2:0]),
    .path  (path),
    .shamt (shamt)
  );

  nsu_subnorm_shift #(.DM(DM), .SHW(SHW)) u_shift (
    .man_hi (man_hi),
    .shamt  (shamt),
    .frac   (subn_frac)
  );

  nsu_pack #(.DE(DE), .DM(DM)) u_pack (
    .sign      (in_word[SW-1]),
    .exp_top   (in_word[SW-2]),
    .exp_low   (in_word[SM+DE-2:SM]),
    .man_hi    (man_hi),
    .subn_frac (subn_frac),
    .path      (path),
    .word      (next_word)
  );

  nsu_out_reg #(.W(DW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .d       (next_word),
    .out_vld (out_vld),
    .q       (out_word)
  );

  // R7
  sign_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (out_word[DW-1] == $past(in_word[SW-1])));

  // R6
  flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (path == PATH_FLUSH)) |=> (out_word[DW-2:0] == '0));

  // R5
  subn_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (path == PATH_SUBN)) |=> (out_word[DW-2:DM] == '0));

endmodule

// File: tb/narrow_store_unit_tb_top.sv
module narrow_store_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [63:0] in_word = '0;
  logic        out_vld;
  logic [31:0] out_word;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  narrow_store_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_word  (in_word),
    .out_vld  (out_vld),
    .out_word (out_word)
  );

  // {requirement number, input, expected}
  localparam int NV = 22;
  localparam logic [103:0] VEC [0:NV-1] = '{
    {8'd1, 64'h3FF0000000000000, 32'h3F800000},  // R1 one
    {8'd1, 64'hC000000000000000, 32'hC0000000},  // R1 minus two
    {8'd1, 64'h3810000000000000, 32'h00800000},  // R1 smallest normal
    {8'd1, 64'h47EFFFFFE0000000, 32'h7F7FFFFF},  // R1 largest single
    {8'd2, 64'h3FF000001FFFFFFF, 32'h3F800000},  // R2 truncation
    {8'd2, 64'h3FF0000020000000, 32'h3F800001},  // R2 lowest kept bit
    {8'd3, 64'h7FF0000000000000, 32'h7F800000},  // R3 +inf
    {8'd3, 64'hFFF0000000000000, 32'hFF800000},  // R3 -inf
    {8'd3, 64'h7FF8000000000000, 32'h7FC00000},  // R3 NaN
    {8'd3, 64'h4C70000000000000, 32'h63800000},  // R3 2^200 raw copy
    {8'd3, 64'h47F0000000000000, 32'h7F800000},  // R3 just above range
    {8'd4, 64'h0000000000000000, 32'h00000000},  // R4 +0
    {8'd4, 64'h8000000000000000, 32'h80000000},  // R4 -0
    {8'd5, 64'h3800000000000000, 32'h00400000},  // R5 shift 1
    {8'd5, 64'h3808000000000000, 32'h00600000},  // R5 with fraction
    {8'd5, 64'h36A0000000000000, 32'h00000001},  // R5 shift 23
    {8'd5, 64'h36AFFFFFFFFFFFFF, 32'h00000001},  // R5 truncated
    {8'd6, 64'h3690000000000000, 32'h00000000},  // R6 just below
    {8'd6, 64'h0000000000000001, 32'h00000000},  // R6 double denormal
    {8'd7, 64'hB6A0000000000000, 32'h80000001},  // R7 negative denormal
    {8'd7, 64'h8000000000000001, 32'h80000000},  // R7 negative flush
    {8'd7, 64'hB800000000000000, 32'h80400000}   // R7 negative shift 1
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  task automatic check_word(input string rq, input logic [31:0] exp_w);
    applied++;
    if (out_word !== exp_w) begin
      miscompares++;
      $display("FAIL %s out_word actual=%h expected=%h", rq, out_word, exp_w);
    end
  endtask

  task automatic check_vld(input string rq, input logic exp_v);
    applied++;
    if (out_vld !== exp_v) begin
      miscompares++;
      $display("FAIL %s out_vld actual=%b expected=%b", rq, out_vld, exp_v);
    end
  endtask

  // drive on falling edge, result registered at next rising edge, sample on falling edge
  task automatic push(input logic v, input logic [63:0] w);
    in_vld  = v;
    in_word = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R10: reset with in_vld high still leaves out_vld low
    @(negedge clk);
    rst = 1'b1;
    push(1'b1, 64'h3FF0000000000000);
    check_vld("R10", 1'b0);
    push(1'b1, 64'h3FF0000000000000);
    check_vld("R10", 1'b0);
    rst = 1'b0;
    push(1'b0, '0);
    check_vld("R10", 1'b0);

    // table walk: back-to-back valid inputs (R8 latency on every vector)
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][103:96]);
      push(1'b1, VEC[i][95:32]);
      check_vld("R8", 1'b1);
      check_word(rq, VEC[i][31:0]);
    end

    // R9: idle with a different word holds the previous result; R8 valid drops
    push(1'b1, 64'hC000000000000000);
    check_word("R1", 32'hC0000000);
    push(1'b0, 64'h3FF0000000000000);
    check_vld("R8", 1'b0);
    check_word("R9", 32'hC0000000);
    push(1'b0, 64'h7FF0000000000000);
    check_word("R9", 32'hC0000000);

    // R8: single accepted input after idle
    push(1'b1, 64'h3800000000000000);
    check_vld("R8", 1'b1);
    check_word("R5", 32'h00400000);

    // R10: mid-run reset clears valid
    rst = 1'b1;
    push(1'b1, 64'h3FF0000000000000);
    check_vld("R10", 1'b0);
    rst = 1'b0;
    push(1'b0, '0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule